// File: doc/BRIEF.md
# Palette-Based Pixel Format Expander

This block sits between a framebuffer byte stream and a display pipeline. It accepts bytes on a valid/ready input, unpacks them according to a colour-depth code, and emits one 24-bit RGB pixel per output handshake. Three depths are indirect: each pixel is 2, 4 or 8 bits wide and selects one of 256 palette entries holding 12-bit colours. Two formats are direct and use 16 bits per pixel. With the panel-type input `tft_mode` low, the halfword carries a 4:4:4 colour in its low 12 bits. With it high, the halfword is a 5:6:5 colour.

The palette is loaded through a write port. Bits 14:12 of the value written to entry 0 also set the depth code, so software programs the depth in the same store as the first palette colour. The output stream carries an end-of-line flag on the last pixel of every line. The line length is programmed as the pixel count minus one. A line always starts on a fresh input byte.

Top module: `pal_pixel_expander`

## Requirements
- R1: The depth code is bits 14:12 of the last value written to palette entry 0. Code 1 selects 2 bpp, code 2 selects 4 bpp, code 3 selects 8 bpp, and codes 4 to 7 select 16 bpp. With code 0, `in_ready` stays low and no pixel is produced.
- R2: At 2 bpp, each byte yields up to four palette pixels. They are taken from bits 1:0 first, then bits 3:2, 5:4 and 7:6.
- R3: At 4 bpp, each byte yields up to two palette pixels, with bits 3:0 first and bits 7:4 second.
- R4: At 8 bpp, each byte yields exactly one pixel, and the whole byte is the palette index.
- R5: A 12-bit colour e expands to `px_rgb` = {e[11:8],4'h0, e[7:4],4'h0, e[3:0],4'h0}. Red is in bits 23:16, green in 15:8 and blue in 7:0.
- R6: At 16 bpp, two input bytes form a halfword v, with the first byte as v[7:0]. With `tft_mode` low, the pixel is the R5 expansion of v[11:0], and v[15:12] have no effect.
- R7: At 16 bpp with `tft_mode` high, `px_rgb` = {v[15:11],3'b0, v[10:5],2'b0, v[4:0],3'b0}.
- R8: `px_eol` is high on every (`line_len_m1`+1)-th output pixel and low on all others. The count restarts after each flagged pixel.
- R9: When a line ends part-way through a 2 or 4 bpp byte, the unused pixels of that byte are discarded. The next line starts with the next input byte.
- R10: While `px_valid` is high and `px_ready` is low, `px_valid`, `px_rgb` and `px_eol` hold their values.
- R11: Suppose a palette write and a lookup of the same index fall in one cycle. The lookup uses the old entry, and the new entry applies from the next lookup.
- R12: After reset, `px_valid` is low, the depth code is 0 and the line position is at the start of a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Framebuffer byte |
| in_valid | input | 1 | Byte valid |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| tft_mode | input | 1 | 16-bit format select: 0 = 4:4:4, 1 = 5:6:5 |
| line_len_m1 | input | COL_W | Pixels per line minus one |
| pal_we | input | 1 | Palette write strobe |
| pal_waddr | input | 8 | Palette entry index |
| pal_wdata | input | 15 | Bits 11:0 are the colour; bits 14:12 are the depth code when the index is 0 |
| px_rgb | output | 24 | Pixel colour, red in the top byte |
| px_valid | output | 1 | Pixel valid |
| px_ready | input | 1 | Pixel accepted when high together with px_valid |
| px_eol | output | 1 | Last pixel of a line |

## Verification
A palette write can land in the same cycle as a lookup of the entry it replaces. The bench provokes this collision by stalling the output so that a fetched byte waits in the holding register. It then raises `px_ready` and writes that byte's palette index on the same clock edge. The scoreboard expects the pixel from the waiting byte to carry the old colour and a later byte with the same index to carry the new one. The bench also checks a line end that falls inside a 2 bpp byte, where the end-of-line flag and the discarding of the rest of the byte happen in the same cycle.

// File: rtl/pal_pixel_expander.sv
module pal_pixel_expander #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             tft_mode,
  input  logic [COL_W-1:0] line_len_m1,
  input  logic             pal_we,
  input  logic [7:0]       pal_waddr,
  input  logic [14:0]      pal_wdata,
  output logic [23:0]      px_rgb,
  output logic             px_valid,
  input  logic             px_ready,
  output logic             px_eol
);
  localparam int PAL_N = 256;

  logic [11:0]      pal_mem [PAL_N];
  logic [2:0]       depth_code;
  logic [7:0]       hold_byte;
  logic [2:0]       hold_cnt;
  logic [7:0]       lo_byte;
  logic             lo_have;
  logic [COL_W-1:0] col;

  wire is2      = depth_code == 3'd1;
  wire is4      = depth_code == 3'd2;
  wire is8      = depth_code == 3'd3;
  wire is16     = depth_code[2];
  wire pal_mode = is2 | is4 | is8;

  wire can_out  = !px_valid || px_ready;
  wire at_eol   = col == line_len_m1;
  wire emit_pal = pal_mode && (hold_cnt != 3'd0) && can_out;
  wire hold_end = (hold_cnt == 3'd1) || at_eol;

  always_comb begin
    if (pal_mode)  in_ready = (hold_cnt == 3'd0) || (emit_pal && hold_end);
    else if (is16) in_ready = !lo_have || can_out;
    else           in_ready = 1'b0;
  end

  wire in_fire = in_valid && in_ready;
  wire emit16  = is16 && lo_have && in_fire;
  wire emit    = emit_pal || emit16;

  logic [7:0]  idx;
  logic [11:0] pal_rd;
  logic [15:0] hw;
  logic [23:0] rgb_next;
  logic [2:0]  per_byte;

  always_comb begin
    if (is2)      idx = {6'd0, hold_byte[1:0]};
    else if (is4) idx = {4'd0, hold_byte[3:0]};
    else          idx = hold_byte;
    per_byte = is2 ? 3'd4 : (is4 ? 3'd2 : 3'd1);
  end

  assign pal_rd = pal_mem[idx];
  assign hw     = {in_data, lo_byte};

  always_comb begin
    if (is16 && tft_mode)
      rgb_next = {hw[15:11], 3'b0, hw[10:5], 2'b0, hw[4:0], 3'b0};
    else if (is16)
      rgb_next = {hw[11:8], 4'h0, hw[7:4], 4'h0, hw[3:0], 4'h0};
    else
      rgb_next = {pal_rd[11:8], 4'h0, pal_rd[7:4], 4'h0, pal_rd[3:0], 4'h0};
  end

  always_ff @(posedge clk)
    if (pal_we) pal_mem[pal_waddr] <= pal_wdata[11:0];

  always_ff @(posedge clk) begin
    if (!rst_n)
      depth_code <= 3'd0;
    else if (pal_we && pal_waddr == 8'd0)
      depth_code <= pal_wdata[14:12];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_byte <= 8'd0;
      hold_cnt  <= 3'd0;
    end else if (in_fire && pal_mode) begin
      hold_byte <= in_data;
      hold_cnt  <= per_byte;
    end else if (emit_pal) begin
      hold_cnt  <= at_eol ? 3'd0 : hold_cnt - 3'd1;
      hold_byte <= is2 ? {2'b0, hold_byte[7:2]} : (is4 ? {4'b0, hold_byte[7:4]} : 8'd0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_have <= 1'b0;
      lo_byte <= 8'd0;
    end else if (in_fire && is16) begin
      lo_have <= !lo_have;
      if (!lo_have) lo_byte <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      px_valid <= 1'b0;
      px_rgb   <= 24'd0;
      px_eol   <= 1'b0;
      col      <= '0;
    end else begin
      if (emit) begin
        px_valid <= 1'b1;
        px_rgb   <= rgb_next;
        px_eol   <= at_eol;
        col      <= at_eol ? '0 : col + 1'b1;
      end else if (px_ready) begin
        px_valid <= 1'b0;
      end
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid && !px_ready |=> px_valid && $stable(px_rgb) && $stable(px_eol)); // R10

  AST_CODE0_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    depth_code == 3'd0 && !px_valid |=> !px_valid); // R1

  AST_LOW_NIBBLES: assert property (@(posedge clk) disable iff (!rst_n)
    px_valid && !(is16 && tft_mode) |-> px_rgb[19:16] == 4'h0 && px_rgb[11:8] == 4'h0 && px_rgb[3:0] == 4'h0); // R5

  AST_BYTE_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && pal_mode |=> hold_cnt != 3'd0); // R4

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> !px_valid && !in_ready); // R12
endmodule

// File: tb/pal_pixel_expander_tb.sv
module pal_pixel_expander_tb_top;
  localparam int COL_W = 10;
  localparam logic [COL_W-1:0] LEN_M1 = 10'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic tft_mode = 1'b0;
  logic pal_we = 1'b0;
  logic [7:0] pal_waddr = 8'd0;
  logic [14:0] pal_wdata = 15'd0;
  logic [23:0] px_rgb;
  logic px_valid;
  logic px_ready;
  logic px_eol;

  always #4 clk = ~clk;

  pal_pixel_expander #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .tft_mode(tft_mode), .line_len_m1(LEN_M1), .pal_we(pal_we), .pal_waddr(pal_waddr),
    .pal_wdata(pal_wdata), .px_rgb(px_rgb), .px_valid(px_valid), .px_ready(px_ready),
    .px_eol(px_eol)
  );

  int checks = 0;
  int fails = 0;
  logic [24:0] exp_q[$];
  int tag_q[$];
  int cur_req = 0;

  logic [11:0] mpal [256];
  int m_code = 0;
  logic [7:0] m_lo_byte = 8'd0;
  bit m_lo = 0;
  int mcol = 0;

  logic [15:0] lfsr = 16'hACE1;
  bit manual = 0;
  logic man_rdy = 1'b0;
  assign px_ready = manual ? man_rdy : (lfsr[0] | lfsr[1]);
  always @(posedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  function automatic logic [23:0] x12(input logic [11:0] e);
    return {e[11:8], 4'h0, e[7:4], 4'h0, e[3:0], 4'h0};
  endfunction

  function automatic void push_px(input logic [23:0] rgb);
    bit eol;
    eol = (mcol == int'(LEN_M1));
    exp_q.push_back({eol, rgb});
    tag_q.push_back(eol ? 8 : cur_req); // R8 on line ends
    mcol = eol ? 0 : mcol + 1;
  endfunction

  task automatic model_byte(input logic [7:0] b);
    int bits;
    int n;
    bit done;
    logic [7:0] v;
    logic [15:0] hw;
    logic [7:0] mask;
    if (m_code >= 1 && m_code <= 3) begin
      bits = (m_code == 1) ? 2 : ((m_code == 2) ? 4 : 8);
      n = 8 / bits;
      mask = (m_code == 1) ? 8'h03 : ((m_code == 2) ? 8'h0F : 8'hFF);
      v = b;
      done = 0;
      for (int k = 0; k < n; k++) begin
        if (!done) begin
          done = (mcol == int'(LEN_M1)); // R9: rest of byte dropped at line end
          push_px(x12(mpal[v & mask]));
          v = v >> bits;
        end
      end
    end else if (m_code >= 4) begin
      if (!m_lo) begin
        m_lo_byte = b;
        m_lo = 1;
      end else begin
        hw = {b, m_lo_byte};
        m_lo = 0;
        if (tft_mode) push_px({hw[15:11], 3'b0, hw[10:5], 2'b0, hw[4:0], 3'b0});
        else push_px(x12(hw[11:0]));
      end
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    in_data = b;
    in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) break;
    end
    model_byte(b);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic pal_write(input logic [7:0] a, input logic [14:0] d);
    pal_we = 1'b1;
    pal_waddr = a;
    pal_wdata = d;
    @(posedge clk); #1;
    pal_we = 1'b0;
    mpal[a] = d[11:0];
    if (a == 8'd0) m_code = int'(d[14:12]);
  endtask

  task automatic set_code(input int code);
    pal_write(8'd0, {code[2:0], mpal[0]});
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || px_valid) @(posedge clk);
    #1;
  endtask

  always @(negedge clk) begin
    logic [24:0] e;
    int t;
    if (rst_n && px_valid && px_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R10 unexpected pixel rgb=%h eol=%b expected none", px_rgb, px_eol);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({px_eol, px_rgb} !== e) begin
          fails++;
          $display("FAIL R%0d rgb=%h eol=%b expected rgb=%h eol=%b", t, px_rgb, px_eol, e[23:0], e[24]);
        end
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: got hang, expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mpal[i] = 12'd0;
    repeat (4) @(posedge clk);
    #1;
    // R12: reset state
    checks++;
    if (px_valid !== 1'b0) begin fails++; $display("FAIL R12 px_valid=%b expected 0", px_valid); end
    checks++;
    if (in_ready !== 1'b0) begin fails++; $display("FAIL R12 in_ready=%b expected 0", in_ready); end
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1: code 0 holds input off
    in_valid = 1'b1;
    in_data = 8'h5A;
    repeat (6) @(posedge clk);
    @(negedge clk);
    checks++;
    if (in_ready !== 1'b0) begin fails++; $display("FAIL R1 in_ready=%b expected 0", in_ready); end
    checks++;
    if (px_valid !== 1'b0) begin fails++; $display("FAIL R1 px_valid=%b expected 0", px_valid); end
    @(posedge clk); #1;
    in_valid = 1'b0;

    for (int i = 0; i < 256; i++)
      pal_write(i[7:0], {3'd0, 12'((i * 167 + 'h35a) & 'hfff)});

    // R2: 2 bpp, bits 1:0 first
    cur_req = 2;
    set_code(1);
    send_byte(8'hE4); send_byte(8'h1B); send_byte(8'hC6); send_byte(8'h39);
    drain();

    // R9: line end in the middle of a 2 bpp byte
    cur_req = 9;
    while (mcol != 4) send_byte(8'h93);
    send_byte(8'hD2);
    send_byte(8'h4E);
    drain();

    // R3: 4 bpp, low nibble first
    cur_req = 3;
    set_code(2);
    send_byte(8'h1F); send_byte(8'hA7); send_byte(8'h3C); send_byte(8'h90); send_byte(8'h65);
    drain();

    // R4, R5: 8 bpp indices including both ends
    cur_req = 4;
    set_code(3);
    send_byte(8'h00); send_byte(8'hFF); send_byte(8'h80); send_byte(8'h7F);
    for (int i = 0; i < 9; i++) send_byte(8'(i * 29 + 3));
    drain();

    // R6: 16 bpp 4:4:4, upper nibble ignored
    cur_req = 6;
    tft_mode = 1'b0;
    set_code(4);
    send_byte(8'h21); send_byte(8'hF3);
    send_byte(8'hFF); send_byte(8'h0F);
    send_byte(8'h00); send_byte(8'hA0);
    set_code(7);
    send_byte(8'h5C); send_byte(8'h7B);
    drain();

    // R7: 16 bpp 5:6:5
    cur_req = 7;
    tft_mode = 1'b1;
    set_code(5);
    send_byte(8'hFF); send_byte(8'hFF);
    send_byte(8'h1F); send_byte(8'h00);
    send_byte(8'hE0); send_byte(8'h07);
    send_byte(8'h00); send_byte(8'hF8);
    send_byte(8'h34); send_byte(8'h12);
    drain();
    tft_mode = 1'b0;

    // R11: palette write in the same cycle as a lookup of that entry
    cur_req = 11;
    set_code(3);
    pal_write(8'd5, 15'h0ABC);
    manual = 1;
    man_rdy = 1'b0;
    send_byte(8'd5);
    send_byte(8'd5);
    @(posedge clk); #1;
    man_rdy = 1'b1;
    pal_we = 1'b1;
    pal_waddr = 8'd5;
    pal_wdata = 15'h0123;
    @(posedge clk); #1;
    pal_we = 1'b0;
    mpal[5] = 12'h123;
    send_byte(8'd5);
    drain();
    manual = 0;

    // R10: stream under random backpressure
    cur_req = 10;
    set_code(1);
    for (int i = 0; i < 20; i++) send_byte(8'(i * 53 + 7));
    drain();

    finish_run();
  end
endmodule